// File: doc/BRIEF.md
# Bridge Parity and Abort Status Logic

This block keeps the error-reporting state for one side of a bus-to-bus bridge. Each clock it looks at the parity check result of the current data phase, at a parity-error report seen on the bus from the far device, and at whether the bridge is the initiator (master) or the responder on that phase. Two sticky status flags record parity trouble. The block also drives the active-low parity-error output with its own output enable.

It also picks the response that the forwarding path gives back to the original requester. A target abort seen on the destination bus during a forwarded write is passed back as a target abort. The same event during a forwarded read turns into a disconnect, after the data already fetched has been delivered. A request that arrives on the primary side while the secondary side is held in reset is answered according to a master-abort-mode control bit.

Parity generation, the rest of the configuration space and the bus protocol sequencers are outside this block. The command and bridge-control registers come in as plain vectors.

Top module: `brg_err_status`

## Requirements
- R1: When a data phase has bad parity and bit 6 of `cmd_reg_i` (parity response enable) is 1, `perr_n_o` goes low for exactly one cycle, in the second cycle after that data phase. With the enable at 0, bad parity never drives `perr_n_o` low.
- R2: `perr_oe_o` is high in every cycle in which `perr_n_o` is low, and also in the cycle that follows it. Otherwise it is low.
- R3: Bit 15 of `stat_o` (detected parity error) is set on the clock edge that ends any data phase with bad parity, whatever the enable bit is.
- R4: Bit 8 of `stat_o` (master data parity error) is set on the clock edge that ends a cycle only when all three of these hold in that cycle: the enable bit is 1, `is_master_i` is 1, and either a bad-parity data phase or `remote_perr_i` is present. In no other case is it set.
- R5: Bits 15 and 8 are sticky. A cycle with `stat_wr_i` high clears each bit whose position holds 1 in `stat_wdata_i`, from the next cycle on. A 0 in that position leaves the bit unchanged. All other bits of `stat_o` always read 0.
- R6: If a set condition and a write-one-to-clear reach the same bit in the same cycle, the bit stays 1.
- R7: `tabort_rcvd_i` with `burst_write_i`=1 gives a one-cycle pulse on `rsp_target_abort_o` in the next cycle.
- R8: `tabort_rcvd_i` with `burst_write_i`=0 gives a one-cycle pulse on `rsp_disconnect_o` in the next cycle, and no target abort.
- R9: `prim_req_i` while `sec_rst_i` is 1 gives, in the next cycle, `rsp_target_abort_o` if bit 5 of `brctl_reg_i` (master-abort mode) is 1, or `rsp_all_ones_o` if that bit is 0. This takes precedence over a target abort in the same cycle.
- R10: During reset `stat_o` is 0, `perr_n_o` is 1, `perr_oe_o` is 0 and all three response outputs are 0. At most one response output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dphase_vld_i | input | 1 | A data phase completes in this cycle |
| dphase_par_bad_i | input | 1 | Parity check of this data phase failed |
| is_master_i | input | 1 | Bridge is the initiator of the current transfer |
| remote_perr_i | input | 1 | Parity error reported on the bus by the far device |
| cmd_reg_i | input | CMD_W | Command register value; bit 6 enables parity response |
| brctl_reg_i | input | CMD_W | Bridge control register value; bit 5 selects master-abort mode |
| stat_wr_i | input | 1 | Write strobe for the status register |
| stat_wdata_i | input | CMD_W | Write data; a 1 clears the matching sticky bit |
| stat_o | output | CMD_W | Status register value (bits 15 and 8 live) |
| perr_n_o | output | 1 | Parity error output, active low |
| perr_oe_o | output | 1 | Output enable for perr_n_o |
| tabort_rcvd_i | input | 1 | Target abort received on the destination bus |
| burst_write_i | input | 1 | The forwarded burst is a write (1) or read (0) |
| sec_rst_i | input | 1 | Secondary side held in reset |
| prim_req_i | input | 1 | Request attempted on the primary side |
| rsp_target_abort_o | output | 1 | Return target abort to the requester |
| rsp_disconnect_o | output | 1 | Deliver fetched data, then disconnect |
| rsp_all_ones_o | output | 1 | Complete the request with all-ones data, no error |

## Verification
Each result has a fixed latency from its cause. The two status bits and all three response pulses change on the first edge after the causing cycle. The parity-error output goes low one edge later, and its enable drops one more edge after that. The bench drives inputs on the falling edge. A behavioural model updates on each rising edge from the inputs it sees there, and all outputs are compared shortly after that edge, so every check lands exactly in the cycle where the requirement says the value is due. The sequences cover the enable off and on, the target and master roles, back-to-back bad phases, set and clear colliding in one cycle, and a target abort arriving together with a secondary-reset request.

// File: rtl/brg_err_pkg.sv
package brg_err_pkg;

   // Response the forwarding path gives back to the original requester
   typedef enum logic [1:0] {
      RSP_NONE       = 2'd0,
      RSP_TABORT     = 2'd1,
      RSP_DISCONNECT = 2'd2,
      RSP_ALL_ONES   = 2'd3
   } fwd_rsp_e;

   // A request during secondary reset outranks an abort seen on the far bus
   function automatic fwd_rsp_e pick_rsp(
      input logic tabort,
      input logic is_write,
      input logic sec_rst,
      input logic prim_req,
      input logic mam
   );
      if (sec_rst && prim_req)
         return mam ? RSP_TABORT : RSP_ALL_ONES;
      else if (tabort)
         return is_write ? RSP_TABORT : RSP_DISCONNECT;
      else
         return RSP_NONE;
   endfunction

endpackage

// File: rtl/brg_perr_pipe.sv
module brg_perr_pipe #(
   parameter int DELAY   = 2,
   parameter bit OE_TAIL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_i,
   output logic perr_n_o,
   output logic oe_o
);

   if (DELAY < 2) begin : g_bad_delay
      $error("brg_perr_pipe: DELAY must be at least 2");
   end

   logic [DELAY-1:0] stage_q;
   logic             active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[DELAY-2:0], flag_i};
   end

   assign active   = stage_q[DELAY-1];
   assign perr_n_o = ~active;

   if (OE_TAIL) begin : g_tail
      logic tail_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tail_q <= 1'b0;
         else        tail_q <= active;
      end
      assign oe_o = active | tail_q;
   end else begin : g_no_tail
      assign oe_o = active;
   end

endmodule

// File: rtl/brg_w1c_bit.sv
module brg_w1c_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   // A set in the same cycle as a clear keeps the bit high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

endmodule

// File: rtl/brg_abort_reflect.sv
module brg_abort_reflect
   import brg_err_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tabort_i,
   input  logic is_write_i,
   input  logic sec_rst_i,
   input  logic prim_req_i,
   input  logic mam_i,
   output logic rsp_tabort_o,
   output logic rsp_disc_o,
   output logic rsp_ones_o
);

   fwd_rsp_e rsp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_q <= RSP_NONE;
      else        rsp_q <= pick_rsp(tabort_i, is_write_i, sec_rst_i, prim_req_i, mam_i);
   end

   assign rsp_tabort_o = (rsp_q == RSP_TABORT);
   assign rsp_disc_o   = (rsp_q == RSP_DISCONNECT);
   assign rsp_ones_o   = (rsp_q == RSP_ALL_ONES);

endmodule

// File: rtl/brg_err_status.sv
module brg_err_status #(
   parameter int CMD_W      = 16,
   parameter int PER_BIT    = 6,
   parameter int MAM_BIT    = 5,
   parameter int DPE_BIT    = 15,
   parameter int MDPE_BIT   = 8,
   parameter int PERR_DELAY = 2,
   parameter bit OE_TAIL    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dphase_vld_i,
   input  logic             dphase_par_bad_i,
   input  logic             is_master_i,
   input  logic             remote_perr_i,
   input  logic [CMD_W-1:0] cmd_reg_i,
   input  logic [CMD_W-1:0] brctl_reg_i,
   input  logic             stat_wr_i,
   input  logic [CMD_W-1:0] stat_wdata_i,
   output logic [CMD_W-1:0] stat_o,
   output logic             perr_n_o,
   output logic             perr_oe_o,
   input  logic             tabort_rcvd_i,
   input  logic             burst_write_i,
   input  logic             sec_rst_i,
   input  logic             prim_req_i,
   output logic             rsp_target_abort_o,
   output logic             rsp_disconnect_o,
   output logic             rsp_all_ones_o
);

   localparam int NSTK = 2;
   localparam int STK_POS [NSTK] = '{DPE_BIT, MDPE_BIT};

   if (PER_BIT >= CMD_W || MAM_BIT >= CMD_W) begin : g_bad_ctl
      $error("brg_err_status: control bit outside register width");
   end
   if (DPE_BIT >= CMD_W || MDPE_BIT >= CMD_W || DPE_BIT == MDPE_BIT) begin : g_bad_stat
      $error("brg_err_status: status bit positions invalid");
   end

   logic            bad_phase;
   logic            resp_en;
   logic            perr_flag;
   logic [NSTK-1:0] stk_set;
   logic [NSTK-1:0] stk_q;

   assign bad_phase = dphase_vld_i & dphase_par_bad_i;
   assign resp_en   = cmd_reg_i[PER_BIT];
   assign perr_flag = bad_phase & resp_en;

   // Index 0: detected parity (no gating); index 1: master data parity
   assign stk_set[0] = bad_phase;
   assign stk_set[1] = resp_en & is_master_i & (bad_phase | remote_perr_i);

   for (genvar g = 0; g < NSTK; g++) begin : g_stk
      brg_w1c_bit u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (stk_set[g]),
         .clr_i (stat_wr_i & stat_wdata_i[STK_POS[g]]),
         .q_o   (stk_q[g])
      );
   end

   always_comb begin
      stat_o = '0;
      for (int i = 0; i < NSTK; i++) stat_o[STK_POS[i]] = stk_q[i];
   end

   brg_perr_pipe #(
      .DELAY   (PERR_DELAY),
      .OE_TAIL (OE_TAIL)
   ) u_perr (
      .clk      (clk),
      .rst_n    (rst_n),
      .flag_i   (perr_flag),
      .perr_n_o (perr_n_o),
      .oe_o     (perr_oe_o)
   );

   brg_abort_reflect u_rsp (
      .clk          (clk),
      .rst_n        (rst_n),
      .tabort_i     (tabort_rcvd_i),
      .is_write_i   (burst_write_i),
      .sec_rst_i    (sec_rst_i),
      .prim_req_i   (prim_req_i),
      .mam_i        (brctl_reg_i[MAM_BIT]),
      .rsp_tabort_o (rsp_target_abort_o),
      .rsp_disc_o   (rsp_disconnect_o),
      .rsp_ones_o   (rsp_all_ones_o)
   );

endmodule

// File: rtl/brg_err_status_chk.sv
module brg_err_status_chk #(
   parameter int CMD_W      = 16,
   parameter int PER_BIT    = 6,
   parameter int MAM_BIT    = 5,
   parameter int DPE_BIT    = 15,
   parameter int MDPE_BIT   = 8,
   parameter int PERR_DELAY = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dphase_vld_i,
   input logic             dphase_par_bad_i,
   input logic             is_master_i,
   input logic             remote_perr_i,
   input logic [CMD_W-1:0] cmd_reg_i,
   input logic [CMD_W-1:0] brctl_reg_i,
   input logic             stat_wr_i,
   input logic [CMD_W-1:0] stat_wdata_i,
   input logic [CMD_W-1:0] stat_o,
   input logic             perr_n_o,
   input logic             perr_oe_o,
   input logic             tabort_rcvd_i,
   input logic             burst_write_i,
   input logic             sec_rst_i,
   input logic             prim_req_i,
   input logic             rsp_target_abort_o,
   input logic             rsp_disconnect_o,
   input logic             rsp_all_ones_o
);

   if (PERR_DELAY == 2) begin : g_lat
      p_perr_due_r1: assert property (@(posedge clk) disable iff (!rst_n)
         $past(dphase_vld_i & dphase_par_bad_i & cmd_reg_i[PER_BIT], 2) |-> !perr_n_o);
   end

   p_oe_covers_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_n_o |-> perr_oe_o);

   p_oe_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(perr_n_o) |-> perr_oe_o);

   p_dpe_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dphase_vld_i & dphase_par_bad_i) |=> stat_o[DPE_BIT]);

   p_mdpe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_o[MDPE_BIT]) |-> $past(cmd_reg_i[PER_BIT] & is_master_i));

   p_dpe_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o[DPE_BIT] & !(stat_wr_i & stat_wdata_i[DPE_BIT])) |=> stat_o[DPE_BIT]);

   p_dpe_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr_i & stat_wdata_i[DPE_BIT] & !(dphase_vld_i & dphase_par_bad_i))
      |=> !stat_o[DPE_BIT]);

   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr_i & stat_wdata_i[DPE_BIT] & dphase_vld_i & dphase_par_bad_i)
      |=> stat_o[DPE_BIT]);

   p_write_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tabort_rcvd_i & burst_write_i & !(sec_rst_i & prim_req_i)) |=> rsp_target_abort_o);

   p_read_disc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tabort_rcvd_i & !burst_write_i & !(sec_rst_i & prim_req_i)) |=> rsp_disconnect_o);

   p_secrst_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_rst_i & prim_req_i) |=>
         (rsp_target_abort_o == $past(brctl_reg_i[MAM_BIT])) &&
         (rsp_all_ones_o == !$past(brctl_reg_i[MAM_BIT])));

   p_rsp_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_target_abort_o, rsp_disconnect_o, rsp_all_ones_o}));

endmodule

bind brg_err_status brg_err_status_chk #(
   .CMD_W      (CMD_W),
   .PER_BIT    (PER_BIT),
   .MAM_BIT    (MAM_BIT),
   .DPE_BIT    (DPE_BIT),
   .MDPE_BIT   (MDPE_BIT),
   .PERR_DELAY (PERR_DELAY)
) u_chk (.*);

// File: tb/brg_err_status_bench.sv
`timescale 1ns/1ps
module brg_err_status_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dphase_vld_i = 0, dphase_par_bad_i = 0, is_master_i = 0, remote_perr_i = 0;
   logic [15:0] cmd_reg_i = '0, brctl_reg_i = '0, stat_wdata_i = '0;
   logic        stat_wr_i = 0;
   logic        tabort_rcvd_i = 0, burst_write_i = 0, sec_rst_i = 0, prim_req_i = 0;
   logic [15:0] stat_o;
   logic        perr_n_o, perr_oe_o;
   logic        rsp_target_abort_o, rsp_disconnect_o, rsp_all_ones_o;

   int checks = 0;
   int errors = 0;
   string scen = "R10";
   bit done = 0;

   always #2 clk = ~clk;  // 250 MHz

   brg_err_status u_brg_err_status (.*);

   // Behavioural reference model
   bit exp_dpe, exp_mdpe, exp_perr, exp_oe, exp_ta, exp_disc, exp_ones;
   bit perr_hist[$];

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s (%s) %s act=%0h exp=%0h t=%0t", req, scen, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      bit bad, en;
      if (!rst_n) begin
         exp_dpe = 0; exp_mdpe = 0; exp_ta = 0; exp_disc = 0; exp_ones = 0;
         perr_hist = '{0, 0, 0};
      end else begin
         bad = dphase_vld_i && dphase_par_bad_i;
         en  = cmd_reg_i[6];
         if (bad) exp_dpe = 1;
         else if (stat_wr_i && stat_wdata_i[15]) exp_dpe = 0;
         if (en && is_master_i && (bad || remote_perr_i)) exp_mdpe = 1;
         else if (stat_wr_i && stat_wdata_i[8]) exp_mdpe = 0;
         perr_hist.push_front(bad && en);
         void'(perr_hist.pop_back());
         exp_ta = 0; exp_disc = 0; exp_ones = 0;
         if (sec_rst_i && prim_req_i) begin
            exp_ta = brctl_reg_i[5]; exp_ones = !brctl_reg_i[5];
         end else if (tabort_rcvd_i) begin
            exp_ta = burst_write_i; exp_disc = !burst_write_i;
         end
      end
      exp_perr = perr_hist[1];
      exp_oe   = perr_hist[1] || perr_hist[2];
      #1;
      chk("R1",  "perr_n_o",  perr_n_o, !exp_perr);
      chk("R2",  "perr_oe_o", perr_oe_o, exp_oe);
      chk("R3",  "stat_o",    stat_o, {exp_dpe, 6'b0, exp_mdpe, 8'b0}); // R4 R5 R6 bits 8/15
      chk("R7",  "rsp_target_abort_o", rsp_target_abort_o, exp_ta);
      chk("R8",  "rsp_disconnect_o",   rsp_disconnect_o, exp_disc);
      chk("R9",  "rsp_all_ones_o",     rsp_all_ones_o, exp_ones);
      if (!rst_n) chk("R10", "reset_outputs",
         {stat_o, perr_n_o, perr_oe_o, rsp_target_abort_o, rsp_disconnect_o, rsp_all_ones_o},
         {16'h0, 1'b1, 1'b0, 3'b0});
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      dphase_vld_i = 0; dphase_par_bad_i = 0; remote_perr_i = 0; stat_wr_i = 0;
      stat_wdata_i = '0; tabort_rcvd_i = 0; prim_req_i = 0;
   endtask

   task automatic phase(input bit bad);
      @(negedge clk);
      dphase_vld_i = 1; dphase_par_bad_i = bad;
      idle(1);
   endtask

   task automatic wr_stat(input logic [15:0] d);
      @(negedge clk);
      stat_wr_i = 1; stat_wdata_i = d;
      idle(1);
   endtask

   initial begin
      perr_hist = '{0, 0, 0};
      idle(3);
      rst_n = 1; idle(2);

      // R1 R3 R4: bad parity as target, enable on: PERR yes, master bit no
      scen = "R1"; cmd_reg_i[6] = 1; phase(1); phase(0); idle(4);
      // R3: enable off, detected bit still set, no PERR
      scen = "R3"; wr_stat(16'h8000); cmd_reg_i[6] = 0; phase(1); idle(4);
      // R5: write 0 keeps, write 1 clears
      scen = "R5"; wr_stat(16'h7EFF); idle(1); wr_stat(16'h8100); idle(2);
      // R4: master role
      scen = "R4"; is_master_i = 1; remote_perr_i = 1; idle(0);
      @(negedge clk); remote_perr_i = 1; idle(1); idle(1);           // enable off: no set
      cmd_reg_i[6] = 1;
      @(negedge clk); remote_perr_i = 1; idle(1); idle(2);           // remote PERR sets bit 8
      wr_stat(16'h8100); phase(1); idle(4);                          // own bad phase sets bit 8
      wr_stat(16'h8100); is_master_i = 0;
      @(negedge clk); remote_perr_i = 1; idle(1); idle(2);           // target role: no set
      // R6: set and clear in the same cycle
      scen = "R6"; is_master_i = 1;
      @(negedge clk); dphase_vld_i = 1; dphase_par_bad_i = 1; stat_wr_i = 1; stat_wdata_i = 16'h8100;
      idle(1); idle(3);
      // R2: back-to-back bad phases, then a gap
      scen = "R2"; is_master_i = 0;
      @(negedge clk); dphase_vld_i = 1; dphase_par_bad_i = 1;
      @(negedge clk); dphase_vld_i = 1; dphase_par_bad_i = 1;
      idle(1); phase(0); phase(1); idle(5);
      // R7 R8: abort reflection
      scen = "R7"; @(negedge clk); tabort_rcvd_i = 1; burst_write_i = 1; idle(1); idle(2);
      scen = "R8"; @(negedge clk); tabort_rcvd_i = 1; burst_write_i = 0; idle(1); idle(2);
      // R9: secondary reset, both modes, with and without a coincident abort
      scen = "R9"; sec_rst_i = 1; brctl_reg_i[5] = 1;
      @(negedge clk); prim_req_i = 1; idle(1); idle(1);
      brctl_reg_i[5] = 0;
      @(negedge clk); prim_req_i = 1; tabort_rcvd_i = 1; burst_write_i = 1; idle(1); idle(1);
      brctl_reg_i[5] = 1;
      @(negedge clk); prim_req_i = 1; tabort_rcvd_i = 1; burst_write_i = 0; idle(1); idle(1);
      @(negedge clk); tabort_rcvd_i = 1; idle(1); idle(2);           // no primary request
      sec_rst_i = 0;
      // R10: reset again with state set
      scen = "R10"; phase(1); idle(1); rst_n = 0; idle(3); rst_n = 1; idle(3);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule